// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside a memory array and decides, for each incoming request, whether a store is allowed to write. Several hardware contexts can take a reservation on an aligned 16-byte block with a load-linked operation. A later store-conditional from the same context succeeds only if that reservation is still held. Any store to a reserved block, conditional or not, removes every reservation on that block, whichever context holds it. The memory array, its latency and any coherence traffic from other agents are outside this block. It only gates writes and keeps the reservation table.

Reservations live in a small table of flops. Each entry holds a valid bit, the block address and the owning context. A context owns at most one entry at a time. When the table is full and a new reservation arrives, a round-robin pointer picks the entry to evict. The permit and result outputs are registered. They appear one cycle after the request, and the table change lands on the same clock edge.

Top module: `llsc_monitor`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. `wr_permit` and `sc_result` are meaningful only when `rsp_valid` is high and read 0 otherwise.
- R2: The op codes are 0 load, 1 load-linked, 2 store and 3 store-conditional. A load or a load-linked gives `wr_permit`=0 and `sc_result`=0. A load leaves the table unchanged.
- R3: Address bits [3:0] are ignored both when a reservation is recorded and when one is compared. Addresses in different 16-byte blocks never match.
- R4: After a load-linked by context C on a block, a store-conditional by C to any address in that block gives `wr_permit`=1 and `sc_result`=1.
- R5: A store-conditional from a context that holds no reservation on the addressed block gives `wr_permit`=0 and `sc_result`=0, even if another context holds one there.
- R6: A plain store always gives `wr_permit`=1 and `sc_result`=0. It removes every reservation on its block, for all contexts.
- R7: A store-conditional, whether it succeeds or fails, removes every reservation on its block for all contexts. A repeated store-conditional to that block then fails.
- R8: A store-conditional while the table holds no reservations gives `wr_permit`=0 and `sc_result`=0.
- R9: A load-linked from a context that already holds a reservation replaces it. A store-conditional to the old block then fails, and one to the new block succeeds.
- R10: When the table is full, a load-linked from a context without an entry evicts the entry at a round-robin pointer. The pointer starts at entry 0 after reset and advances by one per eviction. A free entry is always chosen lowest index first. A context whose entry was evicted then fails its store-conditional.
- R11: A synchronous active-high `rst` clears all reservations and drives `rsp_valid`, `wr_permit` and `sc_result` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 load, 1 load-linked, 2 store, 3 store-conditional |
| req_addr | input | ADDR_W | Physical byte address |
| req_ctx | input | CTX_W | Requesting hardware context |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| wr_permit | output | 1 | The store may write memory |
| sc_result | output | 1 | Store-conditional result: 1 success, 0 failure |

## Verification
Directed sequences are each aimed at one behaviour:
- Store-conditionals against an empty table separate "no reservations" from "reservation lost".
- Same-block addresses with different low bits separate masking from exact compare.
- A second context touching a reserved block separates per-context ownership from address-only matching.
- Filling the table with more contexts than entries shows both the eviction order and that a free slot is preferred over eviction.

Seeded random traffic then mixes all four ops over a handful of blocks and eight contexts, back-to-back and with idle gaps. A reference model in the bench separates correct cross-context clearing and replacement from near-miss policies.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LD = 2'd0,
    OP_LL = 2'd1,
    OP_ST = 2'd2,
    OP_SC = 2'd3
  } llsc_op_e;
endpackage

// File: rtl/llsc_match.sv
// Parallel compare of the request against every table entry.
module llsc_match #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 28,
  parameter int CTX_W   = 3
) (
  input  logic [ENTRIES-1:0]             ent_vld,
  input  logic [ENTRIES-1:0][TAG_W-1:0]  ent_tag,
  input  logic [ENTRIES-1:0][CTX_W-1:0]  ent_ctx,
  input  logic [TAG_W-1:0]               req_tag,
  input  logic [CTX_W-1:0]               req_ctx,
  output logic [ENTRIES-1:0]             addr_hit,
  output logic [ENTRIES-1:0]             ctx_own,
  output logic                           sc_hit
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign addr_hit[g] = ent_vld[g] && (ent_tag[g] == req_tag);
    assign ctx_own[g]  = ent_vld[g] && (ent_ctx[g] == req_ctx);
  end
  assign sc_hit = |(addr_hit & ctx_own);
endmodule

// File: rtl/llsc_alloc.sv
// Picks the table slot a load-linked writes: own entry, else lowest free, else victim.
module llsc_alloc #(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input  logic [ENTRIES-1:0] ent_vld,
  input  logic [ENTRIES-1:0] ctx_own,
  input  logic [IDX_W-1:0]   rr_ptr,
  output logic [IDX_W-1:0]   slot,
  output logic               evict
);
  logic [IDX_W-1:0] own_idx;
  logic [IDX_W-1:0] free_idx;
  logic             has_own;
  logic             has_free;

  always_comb begin
    own_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (ctx_own[i])  own_idx  = IDX_W'(i);
      if (!ent_vld[i]) free_idx = IDX_W'(i);
    end
  end

  assign has_own  = |ctx_own;
  assign has_free = ~&ent_vld;
  assign evict    = !has_own && !has_free;
  assign slot     = has_own ? own_idx : (has_free ? free_idx : rr_ptr);
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CTX_W     = 3,
  parameter int ENTRIES   = 4,
  parameter int GRAN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CTX_W-1:0]  req_ctx,
  output logic              rsp_valid,
  output logic              wr_permit,
  output logic              sc_result
);
  localparam int TAG_W = ADDR_W - GRAN_BITS;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]            ent_vld;
  logic [ENTRIES-1:0][TAG_W-1:0] ent_tag;
  logic [ENTRIES-1:0][CTX_W-1:0] ent_ctx;
  logic [IDX_W-1:0]              rr_ptr;

  logic [TAG_W-1:0]   req_tag;
  logic               unused_low;
  llsc_op_e           op;
  logic [ENTRIES-1:0] addr_hit;
  logic [ENTRIES-1:0] ctx_own;
  logic               sc_hit;
  logic [IDX_W-1:0]   slot;
  logic               evict;

  // Block granularity: low address bits take no part in record or compare.
  assign req_tag    = req_addr[ADDR_W-1:GRAN_BITS];
  assign unused_low = ^req_addr[GRAN_BITS-1:0];
  assign op         = llsc_op_e'(req_op);

  llsc_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .CTX_W(CTX_W)) u_match (
    .ent_vld (ent_vld),
    .ent_tag (ent_tag),
    .ent_ctx (ent_ctx),
    .req_tag (req_tag),
    .req_ctx (req_ctx),
    .addr_hit(addr_hit),
    .ctx_own (ctx_own),
    .sc_hit  (sc_hit)
  );

  llsc_alloc #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_alloc (
    .ent_vld(ent_vld),
    .ctx_own(ctx_own),
    .rr_ptr (rr_ptr),
    .slot   (slot),
    .evict  (evict)
  );

  // Control state and registered response.
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld   <= '0;
      rr_ptr    <= '0;
      rsp_valid <= 1'b0;
      wr_permit <= 1'b0;
      sc_result <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      wr_permit <= 1'b0;
      sc_result <= 1'b0;
      if (req_valid) begin
        case (op)
          OP_LL: begin
            ent_vld[slot] <= 1'b1;
            if (evict)
              rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
          end
          OP_ST: begin
            wr_permit <= 1'b1;
            ent_vld   <= ent_vld & ~addr_hit;
          end
          OP_SC: begin
            wr_permit <= sc_hit;
            sc_result <= sc_hit;
            ent_vld   <= ent_vld & ~addr_hit;
          end
          default: ;
        endcase
      end
    end
  end

  // Entry payload carries no reset; only the valid bits gate it.
  always_ff @(posedge clk) begin
    if (req_valid && op == OP_LL) begin
      ent_tag[slot] <= req_tag;
      ent_ctx[slot] <= req_ctx;
    end
  end

  p_rsp_next_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_rsp_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid && !wr_permit && !sc_result);
  p_load_no_write_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid && (op == OP_LD || op == OP_LL) |=> !wr_permit && !sc_result);
  p_store_write_r6: assert property (@(posedge clk) disable iff (rst)
    req_valid && op == OP_ST |=> wr_permit && !sc_result);
  p_sc_empty_fail_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid && op == OP_SC && ent_vld == '0 |=> !wr_permit && !sc_result);
  p_result_write_r4: assert property (@(posedge clk) disable iff (rst)
    sc_result |-> wr_permit);
  p_one_per_ctx_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctx_own));
  p_evict_full_r10: assert property (@(posedge clk) disable iff (rst)
    req_valid && op == OP_LL && evict |=> &ent_vld);
endmodule

// File: tb/tb_llsc_monitor.sv
`timescale 1ns/1ps
module tb_llsc_monitor;
  localparam int ADDR_W  = 32;
  localparam int CTX_W   = 3;
  localparam int ENTRIES = 4;

  logic              clk = 1'b0;
  logic              rst;
  logic              req_valid;
  logic [1:0]        req_op;
  logic [ADDR_W-1:0] req_addr;
  logic [CTX_W-1:0]  req_ctx;
  logic              rsp_valid, wr_permit, sc_result;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Reference model state
  bit        m_vld [ENTRIES];
  bit [27:0] m_tag [ENTRIES];
  int        m_ctx [ENTRIES];
  int        m_rr;

  always #2.5 clk = ~clk;

  llsc_monitor #(.ADDR_W(ADDR_W), .CTX_W(CTX_W), .ENTRIES(ENTRIES)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_ctx(req_ctx), .rsp_valid(rsp_valid),
    .wr_permit(wr_permit), .sc_result(sc_result)
  );

  task automatic check(string rq, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < ENTRIES; i++) m_vld[i] = 1'b0;
    m_rr = 0;
  endtask

  task automatic model_step(int op, logic [31:0] addr, int ctx, output bit p, output bit r);
    bit [27:0] t = addr[31:4];
    int own = -1;
    int fr = -1;
    int s;
    bit hit = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (m_vld[i] && m_ctx[i] == ctx) own = i;
      if (!m_vld[i]) fr = i;
      if (m_vld[i] && m_ctx[i] == ctx && m_tag[i] == t) hit = 1'b1;
    end
    p = 1'b0; r = 1'b0;
    case (op)
      1: begin
        if (own >= 0) s = own;
        else if (fr >= 0) s = fr;
        else begin s = m_rr; m_rr = (m_rr + 1) % ENTRIES; end
        m_vld[s] = 1'b1; m_tag[s] = t; m_ctx[s] = ctx;
      end
      2, 3: begin
        p = (op == 2) ? 1'b1 : hit;
        r = (op == 2) ? 1'b0 : hit;
        for (int i = 0; i < ENTRIES; i++)
          if (m_vld[i] && m_tag[i] == t) m_vld[i] = 1'b0;
      end
      default: ;
    endcase
  endtask

  // Drive at a falling edge, response is registered at the next rising edge,
  // sampled at the following falling edge.
  task automatic req(int op, logic [31:0] addr, int ctx, string rq);
    bit ep, er;
    req_valid = 1'b1; req_op = 2'(op); req_addr = addr; req_ctx = CTX_W'(ctx);
    model_step(op, addr, ctx, ep, er);
    @(negedge clk);
    req_valid = 1'b0;
    check(rq, "rsp_valid", int'(rsp_valid), 1);
    check(rq, "wr_permit", int'(wr_permit), int'(ep));
    check(rq, "sc_result", int'(sc_result), int'(er));
  endtask

  task automatic idle(string rq);
    req_valid = 1'b0;
    @(negedge clk);
    check(rq, "idle rsp_valid", int'(rsp_valid), 0);
    check(rq, "idle wr_permit", int'(wr_permit), 0);
  endtask

  task automatic do_reset();
    rst = 1'b1; req_valid = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_op = '0; req_addr = '0; req_ctx = '0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R11", "reset rsp_valid", int'(rsp_valid), 0);
    check("R11", "reset wr_permit", int'(wr_permit), 0);
    check("R11", "reset sc_result", int'(sc_result), 0);
    rst = 1'b0;

    req(3, 32'h100, 0, "R8");           // empty table SC fails
    idle("R1");
    req(2, 32'h100, 0, "R6");           // plain store always writes
    req(0, 32'h100, 0, "R2");           // load: no write
    req(1, 32'h200, 1, "R2");           // LL: no write
    req(3, 32'h20C, 1, "R3");           // same block, other low bits: succeeds (R4)
    req(3, 32'h200, 1, "R7");           // reservation consumed
    req(1, 32'h300, 2, "R6");
    req(1, 32'h308, 3, "R6");
    req(2, 32'h30F, 5, "R6");           // store from an unrelated context clears both
    req(3, 32'h300, 2, "R6");
    req(3, 32'h304, 3, "R6");
    req(1, 32'h400, 1, "R5");
    req(3, 32'h400, 2, "R5");           // other context fails...
    req(3, 32'h400, 1, "R7");           // ...and its failure cleared the block
    req(1, 32'h500, 1, "R9");
    req(1, 32'h600, 1, "R9");           // replaces the previous one
    req(3, 32'h500, 1, "R9");
    req(3, 32'h600, 1, "R9");
    req(1, 32'h4F0, 0, "R3");
    req(3, 32'h500, 0, "R3");           // adjacent block does not match
    req(1, 32'h700, 0, "R11");
    do_reset();
    req(3, 32'h700, 0, "R11");          // reset dropped the reservation
    for (int c = 0; c < 4; c++) req(1, 32'h1000 + 32'(c * 16), c, "R10");
    req(1, 32'h2000, 4, "R10");         // evicts entry 0 (context 0)
    req(3, 32'h1000, 0, "R10");
    req(3, 32'h1010, 1, "R10");         // frees entry 1
    req(1, 32'h2100, 5, "R10");         // takes the free entry
    req(1, 32'h2200, 6, "R10");         // evicts entry 1 (context 5)
    req(3, 32'h2100, 5, "R10");
    req(3, 32'h1020, 2, "R10");
    idle("R1");

    void'($urandom(32'd4321));
    for (int k = 0; k < 3000; k++) begin
      int op = $urandom_range(0, 3);
      logic [31:0] a = 32'h8000 + 32'($urandom_range(0, 5) * 16) + 32'($urandom_range(0, 15));
      int c = $urandom_range(0, 7);
      if (op == 1 && $urandom_range(0, 1) == 1) op = 1;
      req(op, a, c, (op == 3) ? "R4" : (op == 1) ? "R10" : "R6");
      if ($urandom_range(0, 7) == 0) idle("R1");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule